// File: doc/BRIEF.md
# Dual-Channel Edge Capture Timer

This block timestamps signal transitions on two external inputs, called channel A and channel B. A free-running counter advances on every clock. A selectable power-of-two prescale picks which eight bits of the counter form the timestamp. Each input is synchronized and checked for edges. A rising edge stores the timestamp in that channel's rising register, and a falling edge stores it in the falling register. Each edge also raises an event flag.

Software uses a small synchronous register port to read the timestamps, the flags and a configuration byte, and to write the configuration byte. Reading a timestamp register clears its flag. The two flags of a channel, each gated by its own enable bit, drive one level interrupt for that channel. Software reads the status byte to find out which edge raised the interrupt. An optional hold mode keeps the first timestamp until software collects it.

Top module: `edge_capture_timer`

## Requirements
- R1: After reset, all timestamp registers, the configuration byte and the flags are 0, `bus_rdata` is 0, and both interrupts are low.
- R2: The internal counter starts at 0 when reset is released and adds one on every clock (15 bits, wrapping). A timestamp is bits [P+7:P] of the counter value present in the detection cycle, where P is the configuration field bits 6:4.
- R3: Each input is sampled by two flip-flops, and an edge is detected two clocks after the first sample. The timestamp then goes to a register whose address encodes the input and the edge: 0x40 A rising, 0x41 A falling, 0x42 B rising, 0x43 B falling.
- R4: The status byte at 0x45 holds the flags: bit 0 A rising, bit 1 A falling, bit 2 B rising, bit 3 B falling. Bits 7:4 read 0. A detected edge sets its flag, and a read of the matching timestamp register clears it.
- R5: While configuration bit 7 is 1 and a flag is set, further edges of that type leave the timestamp unchanged. The exception is an edge that arrives in the same cycle as the clearing read. When bit 7 is 0, every edge overwrites the timestamp.
- R6: `irq_a` equals (flag0 AND enable bit 0) OR (flag1 AND enable bit 1), and `irq_b` is the same with bits 2 and 3. The enables are configuration bits 3:0, in the same order as the flags.
- R7: The configuration byte at 0x44 is read/write. A read returns the last value written.
- R8: Read data appears on `bus_rdata` in the cycle after `bus_rd`. `bus_rdata` is 0 in every other cycle and for unmapped addresses. Writes to addresses other than 0x44 have no effect.
- R9: If an edge is detected in the same cycle as a read that clears its flag, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_a | input | 1 | Channel A capture input (asynchronous) |
| cap_b | input | 1 | Channel B capture input (asynchronous) |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| irq_a | output | 1 | Channel A interrupt level |
| irq_b | output | 1 | Channel B interrupt level |

## Verification
The assertions assume that `rst_n` is held low long enough to clear the synchronizers. They also assume that the capture inputs are low when reset is released, so no phantom edge appears in the first cycles. The bench therefore drives both inputs low throughout reset. It changes inputs, strobes and addresses only on falling clock edges. It places edges on purpose in the same cycle as reads and configuration writes, so the set-over-clear and hold cases occur inside those stated limits.

// File: rtl/edge_capture_timer.sv
module edge_capture_timer #(
  parameter int             DW    = 8,
  parameter int             PSC_W = 3,
  parameter int             AW    = 8,
  parameter logic [AW-1:0]  BASE  = 8'h40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_a,
  input  logic          cap_b,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_rd,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_a,
  output logic          irq_b
);
  localparam int CNT_W = DW + (1 << PSC_W) - 1;
  localparam int NEV   = 4;

  logic [CNT_W-1:0]        cnt;
  logic [2:0]              sh_a, sh_b;
  logic [NEV-1:0][DW-1:0]  stamp_q;
  logic [NEV-1:0]          flag;
  logic [DW-1:0]           cfg;
  logic [NEV-1:0]          ev, rd_hit, take;
  logic [AW-1:0]           off;
  logic [DW-1:0]           stamp, rd_mux;
  logic                    hold;
  logic [PSC_W-1:0]        psc;

  assign off   = bus_addr - BASE;
  assign hold  = cfg[DW-1];
  assign psc   = cfg[NEV +: PSC_W];
  assign stamp = DW'(cnt >> psc);

  assign ev[0] =  sh_a[1] & ~sh_a[2];
  assign ev[1] = ~sh_a[1] &  sh_a[2];
  assign ev[2] =  sh_b[1] & ~sh_b[2];
  assign ev[3] = ~sh_b[1] &  sh_b[2];

  always_comb begin
    for (int i = 0; i < NEV; i++) begin
      rd_hit[i] = bus_rd && (off == AW'(i));
      take[i]   = ev[i] && (!hold || !flag[i] || rd_hit[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sh_a <= '0;
      sh_b <= '0;
    end else begin
      cnt  <= cnt + 1'b1;
      sh_a <= {sh_a[1:0], cap_a};
      sh_b <= {sh_b[1:0], cap_b};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stamp_q <= '0;
      flag    <= '0;
    end else begin
      for (int i = 0; i < NEV; i++) begin
        if (take[i]) stamp_q[i] <= stamp;
        if (ev[i])          flag[i] <= 1'b1;
        else if (rd_hit[i]) flag[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cfg <= '0;
    else if (bus_wr && off == AW'(NEV)) cfg <= bus_wdata;
  end

  always_comb begin
    rd_mux = '0;
    if (off < AW'(NEV))           rd_mux = stamp_q[off[1:0]];
    else if (off == AW'(NEV))     rd_mux = cfg;
    else if (off == AW'(NEV + 1)) rd_mux = DW'(flag);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= bus_rd ? rd_mux : '0;
  end

  assign irq_a = |(flag[1:0] & cfg[1:0]);
  assign irq_b = |(flag[3:2] & cfg[3:2]);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == $past(cnt) + 1'b1 || $past(!rst_n)); // R2
  AST_STATUS_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && off == AW'(NEV + 1)) |=> bus_rdata[DW-1:NEV] == '0); // R4
  AST_HOLD_A_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && flag[0] && !rd_hit[0]) |=> $stable(stamp_q[0])); // R5
  AST_HOLD_B_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && flag[3] && !rd_hit[3]) |=> $stable(stamp_q[3])); // R5
  AST_IRQ_A_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[1:0] == 2'b00) |-> !irq_a); // R6
  AST_IRQ_B_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[3:2] == 2'b00) |-> !irq_b); // R6
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == '0); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev[0] && rd_hit[0]) |=> flag[0]); // R9
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit[1] && !ev[1]) |=> !flag[1]); // R4
endmodule

// File: tb/tb_edge_capture_timer.sv
module tb_edge_capture_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cap_a = 1'b0, cap_b = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       irq_a, irq_b;

  int checks = 0, errors = 0;
  bit done = 0;

  edge_capture_timer dut (
    .clk(clk), .rst_n(rst_n), .cap_a(cap_a), .cap_b(cap_b),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq_a(irq_a), .irq_b(irq_b)
  );

  always #4 clk = ~clk;

  // behavioural reference model
  int       m_cnt;
  bit [2:0] m_pa, m_pb;
  int       m_cap[4];
  bit [3:0] m_flag;
  int       m_cfg;
  int       m_rdata;
  string    m_tag = "R1";

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_pa = 0; m_pb = 0; m_flag = 0; m_cfg = 0; m_rdata = 0;
      for (int i = 0; i < 4; i++) m_cap[i] = 0;
      m_tag = "R1";
    end else begin
      bit [3:0] e;
      int st, idx;
      e[0] = m_pa[1] && !m_pa[2];
      e[1] = !m_pa[1] && m_pa[2];
      e[2] = m_pb[1] && !m_pb[2];
      e[3] = !m_pb[1] && m_pb[2];
      st  = (m_cnt >> ((m_cfg >> 4) & 7)) & 255;
      idx = bus_rd ? int'(bus_addr) - 'h40 : -1;
      if (!bus_rd) begin
        m_rdata = 0; m_tag = "R8";
      end else if (idx >= 0 && idx < 4) begin
        m_rdata = m_cap[idx];
        m_tag = (m_cfg & 'h80) != 0 ? "R3 R5" : "R2 R3";
      end else if (idx == 4) begin
        m_rdata = m_cfg; m_tag = "R7";
      end else if (idx == 5) begin
        m_rdata = int'(m_flag); m_tag = "R4 R9";
      end else begin
        m_rdata = 0; m_tag = "R8";
      end
      for (int i = 0; i < 4; i++) begin
        if (e[i] && ((m_cfg & 'h80) == 0 || !m_flag[i] || idx == i)) m_cap[i] = st;
        if (e[i]) m_flag[i] = 1;
        else if (idx == i) m_flag[i] = 0;
      end
      if (bus_wr && bus_addr == 8'h44) m_cfg = int'(bus_wdata);
      m_cnt = (m_cnt + 1) % 32768;
      m_pa = {m_pa[1:0], cap_a};
      m_pb = {m_pb[1:0], cap_b};
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      check(m_tag, int'(bus_rdata), m_rdata);
      check("R6", int'(irq_a), int'((m_flag[0] && m_cfg[0]) || (m_flag[1] && m_cfg[1])));
      check("R6", int'(irq_b), int'((m_flag[2] && m_cfg[2]) || (m_flag[3] && m_cfg[3])));
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_rd = 0; bus_wr = 0;
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    bus_rd = 0; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_wr = 0; bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    #1 d = bus_rdata;
  endtask

  initial begin
    #1_600_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (4) @(negedge clk);
    check("R1", int'(bus_rdata), 0);
    check("R1", int'(irq_a | irq_b), 0);
    rst_n = 1;
    idle(3);
    rd(8'h44, d); check("R1", int'(d), 0);
    rd(8'h45, d); check("R1", int'(d), 0);

    wr(8'h44, 8'h0F);
    rd(8'h44, d); check("R7", int'(d), 'h0F);
    wr(8'h47, 8'hFF);
    rd(8'h44, d); check("R8", int'(d), 'h0F);

    // rising edge on A, clearing read lands on detection cycle
    @(negedge clk); cap_a = 1;
    @(negedge clk);
    @(negedge clk); bus_rd = 1; bus_addr = 8'h40;
    @(negedge clk); bus_rd = 0;
    rd(8'h45, d); check("R9", int'(d[0]), 1);
    check("R6", int'(irq_a), 1);
    rd(8'h40, d);
    rd(8'h45, d); check("R4", int'(d[0]), 0);

    // hold mode: second falling edge on B must not overwrite
    wr(8'h44, 8'h9F);
    @(negedge clk); cap_b = 1; idle(6);
    @(negedge clk); cap_b = 0; idle(6);
    @(negedge clk); cap_b = 1; idle(6);
    @(negedge clk); cap_b = 0; idle(20);
    rd(8'h43, d);
    rd(8'h42, d);
    wr(8'h44, 8'h00);
    check("R6", int'(irq_a | irq_b), 0);

    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      bus_rd = 0; bus_wr = 0;
      if ($urandom % 5 == 0) cap_a = ~cap_a;
      if ($urandom % 7 == 0) cap_b = ~cap_b;
      if ($urandom % 3 == 0) begin
        bus_rd = 1; bus_addr = 8'h3E + 8'($urandom % 10);
      end
      if ($urandom % 40 == 0) begin
        bus_wr = 1; bus_wdata = 8'($urandom);
        bus_addr = ($urandom % 2 == 0) ? 8'h44 : 8'h3E + 8'($urandom % 10);
      end
    end
    idle(10);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule